// File: doc/BRIEF.md
# Access-Policy Configuration Register Bank

This block is a bank of ten 8-bit registers reached through a simple CPU port with a read strobe, a write strobe, a 4-bit address and 8-bit write data. Every register carries two fields: a 7-bit field in bits 6:0 and a single-bit field in bit 7. Each slot follows its own pairing of software rights (read-write, read-only or write-only) and hardware rights (read-write, read-only, write-only or no access). Some slots are therefore flops. Others are fixed constants. One is a plain wire that passes a hardware input through to the read path.

Hardware logic around the bank gets the stored value of the slots it may read as output ports. It supplies next values and per-field load strobes for the slots it may write. The CPU reads through a combinational address decode. The decoded byte is captured into a read-data register, and a valid flag goes high one cycle after the read strobe.

Top module: `acc_policy_regbank`

## Requirements
- R1: Reset is synchronous and active high. After reset, the 8-bit values of slots 0,1,2,3,4,8,9 are 0x0A, 0x94, 0x1E, 0xA8, 0x32, 0xDA, 0x64 (bit 7 is the single-bit field, bits 6:0 the wide field), and `cpu_rvalid` is 0.
- R2: Slot 0 (software read-write, hardware read-write) loads `hw_s0_next` field by field. `hw_s0_we` bit 0 enables bits 6:0 and bit 1 enables bit 7, both active high. The stored value appears on `hw_s0_q` one cycle later.
- R3: Slot 2 (software read-write, hardware write-only) loads `hw_s2_next` field by field only where `hw_s2_we_n` is 0. Bit 0 of the strobe covers bits 6:0 and bit 1 covers bit 7. A 1 leaves the field unchanged.
- R4: Slots 1 and 3 are software read-write storage with no hardware load path. A CPU write is read back unchanged. Slot 1 also drives `hw_s1_q`.
- R5: Slot 4 (software read-only, hardware load with active-high `hw_s4_we`, same bit split as R2) ignores CPU writes, while hardware loads update it and `hw_s4_q`.
- R6: Slot 5 always reads 0xBC and drives 0xBC on `hw_s5_q`. Slot 7 always reads 0x50. CPU writes to either slot change nothing.
- R7: Slot 6 holds no state. A read returns the value of `hw_s6_in` at the read strobe, and CPU writes to slot 6 are ignored.
- R8: Slots 8 and 9 are software write-only. Reads return 0, while writes update `hw_s8_q` and `hw_s9_q`. Slot 8 also takes hardware loads through `hw_s8_next` and active-high `hw_s8_we` (split as R2).
- R9: The single-bit field always reads back in bit 7 of the byte for storage, constant and wire slots alike (for example, slot 6 with input 0x81 reads 0x81).
- R10: A read strobe in cycle N gives `cpu_rvalid`=1 and the decoded byte on `cpu_rdata` in cycle N+1. Without a strobe in cycle N, `cpu_rvalid` is 0 in cycle N+1.
- R11: Addresses 10 to 15 read as 0, and writes to them change no slot.
- R12: When a CPU write and a hardware load hit the same storage slot in one cycle, the CPU write data wins for every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 4 | Slot address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Registered read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after read strobe |
| hw_s0_next | input | 8 | Slot 0 hardware next value |
| hw_s0_we | input | 2 | Slot 0 per-field load, active high |
| hw_s0_q | output | 8 | Slot 0 stored value |
| hw_s1_q | output | 8 | Slot 1 stored value |
| hw_s2_next | input | 8 | Slot 2 hardware next value |
| hw_s2_we_n | input | 2 | Slot 2 per-field load, active low |
| hw_s4_next | input | 8 | Slot 4 hardware next value |
| hw_s4_we | input | 2 | Slot 4 per-field load, active high |
| hw_s4_q | output | 8 | Slot 4 stored value |
| hw_s5_q | output | 8 | Slot 5 constant value |
| hw_s6_in | input | 8 | Slot 6 live value for reads |
| hw_s8_next | input | 8 | Slot 8 hardware next value |
| hw_s8_we | input | 2 | Slot 8 per-field load, active high |
| hw_s8_q | output | 8 | Slot 8 stored value |
| hw_s9_q | output | 8 | Slot 9 stored value |

## Verification
On every cycle, the assertions check the read-valid timing, the wire pass-through of slot 6, zero data from write-only and unmapped addresses, the fixed slot 5 value, CPU priority on slot 0 and the hold of slot 4 under CPU writes. The bench alone covers state that no port shows directly: the active-low loads of slot 2 and the values of slot 3. It compares those read-backs and every hardware output against its own model. That model runs through directed corner cases and a long mixed random sequence.

// File: rtl/acc_regbank_pkg.sv
package acc_regbank_pkg;
  localparam int unsigned NSLOT = 10;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 4;
  localparam int unsigned LO_W  = DW - 1;

  typedef enum logic [1:0] {SW_RW, SW_RO, SW_WO} sw_mode_e;
  typedef enum logic [1:0] {HW_RW, HW_RO, HW_WO, HW_NA} hw_mode_e;
  typedef enum logic [1:0] {KIND_STORE, KIND_CONST, KIND_WIRE} field_kind_e;

  typedef struct packed {
    sw_mode_e sw;
    hw_mode_e hw;
    logic     has_we;
  } policy_t;

  function automatic policy_t slot_policy(int s);
    case (s)
      0:       return '{SW_RW, HW_RW, 1'b1};
      1:       return '{SW_RW, HW_RO, 1'b0};
      2:       return '{SW_RW, HW_WO, 1'b1};
      3:       return '{SW_RW, HW_NA, 1'b0};
      4:       return '{SW_RO, HW_RW, 1'b1};
      5:       return '{SW_RO, HW_RO, 1'b0};
      6:       return '{SW_RO, HW_WO, 1'b0};
      7:       return '{SW_RO, HW_NA, 1'b0};
      8:       return '{SW_WO, HW_RW, 1'b1};
      default: return '{SW_WO, HW_RO, 1'b0};
    endcase
  endfunction

  function automatic logic [DW-1:0] pack_fields(logic [LO_W-1:0] lo, logic hi);
    return {hi, lo};
  endfunction

  function automatic logic [DW-1:0] slot_reset(int s);
    case (s)
      0:       return pack_fields(7'd10, 1'b0);
      1:       return pack_fields(7'd20, 1'b1);
      2:       return pack_fields(7'd30, 1'b0);
      3:       return pack_fields(7'd40, 1'b1);
      4:       return pack_fields(7'd50, 1'b0);
      5:       return pack_fields(7'd60, 1'b1);
      7:       return pack_fields(7'd80, 1'b0);
      8:       return pack_fields(7'd90, 1'b1);
      9:       return pack_fields(7'd100, 1'b0);
      default: return '0;
    endcase
  endfunction

  function automatic logic sw_can_read(policy_t p);
    return p.sw != SW_WO;
  endfunction

  function automatic logic sw_can_write(policy_t p);
    return p.sw != SW_RO;
  endfunction

  function automatic field_kind_e field_kind(policy_t p);
    if (sw_can_write(p) || p.has_we) return KIND_STORE;
    if (p.hw == HW_WO)               return KIND_WIRE;
    return KIND_CONST;
  endfunction
endpackage

// File: rtl/acc_field_cell.sv
module acc_field_cell
  import acc_regbank_pkg::*;
#(
  parameter int unsigned W      = 7,
  parameter logic [W-1:0] RST   = '0,
  parameter field_kind_e  KIND  = KIND_STORE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_we,
  input  logic [W-1:0] sw_d,
  input  logic         hw_we,
  input  logic [W-1:0] hw_d,
  output logic [W-1:0] q
);
  generate
    if (KIND == KIND_STORE) begin : g_store
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst)        q_r <= RST;
        else if (sw_we) q_r <= sw_d;
        else if (hw_we) q_r <= hw_d;
      end
      assign q = q_r;
    end else if (KIND == KIND_WIRE) begin : g_wire
      logic unused_wire;
      assign unused_wire = ^{clk, rst, sw_we, sw_d, hw_we};
      assign q = hw_d;
    end else begin : g_const
      logic unused_const;
      assign unused_const = ^{clk, rst, sw_we, sw_d, hw_we, hw_d};
      assign q = RST;
    end
  endgenerate
endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
  import acc_regbank_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] slot_q [NSLOT],
  output logic [DW-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (addr == AW'(s) && sw_can_read(slot_policy(s))) rd_data = slot_q[s];
    end
  end
endmodule

// File: rtl/acc_policy_regbank.sv
module acc_policy_regbank
  import acc_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [3:0]    cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic          cpu_rvalid,
  input  logic [7:0]    hw_s0_next,
  input  logic [1:0]    hw_s0_we,
  output logic [7:0]    hw_s0_q,
  output logic [7:0]    hw_s1_q,
  input  logic [7:0]    hw_s2_next,
  input  logic [1:0]    hw_s2_we_n,
  input  logic [7:0]    hw_s4_next,
  input  logic [1:0]    hw_s4_we,
  output logic [7:0]    hw_s4_q,
  output logic [7:0]    hw_s5_q,
  input  logic [7:0]    hw_s6_in,
  input  logic [7:0]    hw_s8_next,
  input  logic [1:0]    hw_s8_we,
  output logic [7:0]    hw_s8_q,
  output logic [7:0]    hw_s9_q
);
  logic [DW-1:0]    hw_next_a [NSLOT];
  logic [1:0]       hw_we_a   [NSLOT];
  logic [DW-1:0]    slot_q    [NSLOT];
  logic [NSLOT-1:0] sw_hit;
  logic [1:0]       hw_hit    [NSLOT];
  logic [DW-1:0]    rd_comb;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      hw_next_a[s] = '0;
      hw_we_a[s]   = '0;
    end
    hw_next_a[0] = hw_s0_next;  hw_we_a[0] = hw_s0_we;
    hw_next_a[2] = hw_s2_next;  hw_we_a[2] = ~hw_s2_we_n;
    hw_next_a[4] = hw_s4_next;  hw_we_a[4] = hw_s4_we;
    hw_next_a[6] = hw_s6_in;
    hw_next_a[8] = hw_s8_next;  hw_we_a[8] = hw_s8_we;
  end

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam policy_t     POL  = slot_policy(s);
      localparam field_kind_e KIND = field_kind(POL);
      localparam logic [DW-1:0] RV = slot_reset(s);
      logic [LO_W-1:0] lo_q;
      logic            hi_q;

      assign sw_hit[s] = cpu_wr && (cpu_addr == AW'(s)) && sw_can_write(POL);
      assign hw_hit[s] = POL.has_we ? hw_we_a[s] : 2'b00;

      acc_field_cell #(.W(LO_W), .RST(RV[LO_W-1:0]), .KIND(KIND)) u_lo (
        .clk   (clk),
        .rst   (rst),
        .sw_we (sw_hit[s]),
        .sw_d  (cpu_wdata[LO_W-1:0]),
        .hw_we (hw_hit[s][0]),
        .hw_d  (hw_next_a[s][LO_W-1:0]),
        .q     (lo_q)
      );

      acc_field_cell #(.W(1), .RST(RV[DW-1]), .KIND(KIND)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .sw_we (sw_hit[s]),
        .sw_d  (cpu_wdata[DW-1]),
        .hw_we (hw_hit[s][1]),
        .hw_d  (hw_next_a[s][DW-1]),
        .q     (hi_q)
      );

      assign slot_q[s] = pack_fields(lo_q, hi_q);
    end
  endgenerate

  acc_read_mux u_mux (
    .addr    (cpu_addr),
    .slot_q  (slot_q),
    .rd_data (rd_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata  <= '0;
      cpu_rvalid <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_rd;
      if (cpu_rd) cpu_rdata <= rd_comb;
    end
  end

  assign hw_s0_q = slot_q[0];
  assign hw_s1_q = slot_q[1];
  assign hw_s4_q = slot_q[4];
  assign hw_s5_q = slot_q[5];
  assign hw_s8_q = slot_q[8];
  assign hw_s9_q = slot_q[9];
endmodule

// File: rtl/acc_regbank_checker.sv
module acc_regbank_checker (
  input logic       clk,
  input logic       rst,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic [3:0] cpu_addr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       cpu_rvalid,
  input logic [7:0] hw_s0_next,
  input logic [1:0] hw_s0_we,
  input logic [7:0] hw_s0_q,
  input logic [7:0] hw_s1_q,
  input logic [1:0] hw_s4_we,
  input logic [7:0] hw_s4_q,
  input logic [7:0] hw_s5_q,
  input logic [7:0] hw_s6_in,
  input logic [9:0] sw_hit
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> (hw_s1_q == 8'h94 && !cpu_rvalid));

  assert_hw_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!(cpu_wr && cpu_addr == 4'd0) && hw_s0_we == 2'b11) |=> hw_s0_q == $past(hw_s0_next));

  assert_ro_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 4'd4 && hw_s4_we == 2'b00) |=> $stable(hw_s4_q));

  assert_const_R6: assert property (@(posedge clk) disable iff (rst) hw_s5_q == 8'hBC);

  assert_wire_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 4'd6) |=> cpu_rdata == $past(hw_s6_in));

  assert_wo_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && (cpu_addr == 4'd8 || cpu_addr == 4'd9)) |=> cpu_rdata == 8'h00);

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst) cpu_rd |=> cpu_rvalid);

  assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (rst) !cpu_rd |=> !cpu_rvalid);

  assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr >= 4'd10) |=> cpu_rdata == 8'h00);

  assert_unmapped_wr_R11: assert property (@(posedge clk) disable iff (rst)
    (cpu_addr >= 4'd10) |-> sw_hit == 10'd0);

  assert_sw_wins_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 4'd0) |=> hw_s0_q == $past(cpu_wdata));
endmodule

bind acc_policy_regbank acc_regbank_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .cpu_rvalid (cpu_rvalid),
  .hw_s0_next (hw_s0_next),
  .hw_s0_we   (hw_s0_we),
  .hw_s0_q    (hw_s0_q),
  .hw_s1_q    (hw_s1_q),
  .hw_s4_we   (hw_s4_we),
  .hw_s4_q    (hw_s4_q),
  .hw_s5_q    (hw_s5_q),
  .hw_s6_in   (hw_s6_in),
  .sw_hit     (sw_hit)
);

// File: tb/test_acc_policy_regbank.sv
`timescale 1ns/1ps
module test_acc_policy_regbank;
  logic clk = 0, rst = 1;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [3:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic cpu_rvalid;
  logic [7:0] s0_next = 0, s2_next = 0, s4_next = 0, s6_in = 0, s8_next = 0;
  logic [1:0] s0_we = 0, s2_we_n = 2'b11, s4_we = 0, s8_we = 0;
  logic [7:0] s0_q, s1_q, s4_q, s5_q, s8_q, s9_q;
  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] m [10];

  always #2.5 clk = ~clk;

  acc_policy_regbank i_acc_policy_regbank (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .hw_s0_next(s0_next), .hw_s0_we(s0_we), .hw_s0_q(s0_q), .hw_s1_q(s1_q),
    .hw_s2_next(s2_next), .hw_s2_we_n(s2_we_n), .hw_s4_next(s4_next), .hw_s4_we(s4_we),
    .hw_s4_q(s4_q), .hw_s5_q(s5_q), .hw_s6_in(s6_in), .hw_s8_next(s8_next),
    .hw_s8_we(s8_we), .hw_s8_q(s8_q), .hw_s9_q(s9_q)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] blend(logic [7:0] old, logic [7:0] nv, logic [1:0] en);
    logic [7:0] keep = {~en[1], {7{~en[0]}}};
    return (old & keep) | (nv & ~keep);
  endfunction

  function automatic logic [7:0] model_read(int a);
    case (a)
      0, 1, 2, 3, 4: return m[a];
      5: return 8'd60 + 8'd128;
      6: return s6_in;
      7: return 8'd80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(int a);
    case (a)
      0: return "R2"; 1, 3: return "R4"; 2: return "R3"; 4: return "R5";
      5, 7: return "R6"; 6: return "R7"; 8, 9: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check_outputs();
    chk("R2 s0_q", s0_q, m[0]);
    chk("R4 s1_q", s1_q, m[1]);
    chk("R5 s4_q", s4_q, m[4]);
    chk("R6 s5_q", s5_q, 8'hBC);
    chk("R8 s8_q", s8_q, m[8]);
    chk("R8 s9_q", s9_q, m[9]);
  endtask

  task automatic step(logic w, logic r, logic [3:0] a, logic [7:0] d);
    logic [7:0] exp_rd;
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d;
    exp_rd = model_read(int'(a));
    m[0] = (w && a == 0) ? d : blend(m[0], s0_next, s0_we);
    m[1] = (w && a == 1) ? d : m[1];
    m[2] = (w && a == 2) ? d : blend(m[2], s2_next, ~s2_we_n);
    m[3] = (w && a == 3) ? d : m[3];
    m[4] = blend(m[4], s4_next, s4_we);
    m[8] = (w && a == 8) ? d : blend(m[8], s8_next, s8_we);
    m[9] = (w && a == 9) ? d : m[9];
    @(posedge clk); #1;
    chk("R10 rvalid", {7'd0, cpu_rvalid}, {7'd0, r});
    if (r) chk({read_tag(int'(a)), " rdata"}, cpu_rdata, exp_rd);
    check_outputs();
    cpu_wr = 0; cpu_rd = 0;
  endtask

  task automatic hw_idle();
    s0_we = 0; s2_we_n = 2'b11; s4_we = 0; s8_we = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    m[0] = 8'h0A; m[1] = 8'h94; m[2] = 8'h1E; m[3] = 8'hA8; m[4] = 8'h32;
    m[5] = 0; m[6] = 0; m[7] = 0; m[8] = 8'hDA; m[9] = 8'h64;
    // R1 reset state
    chk("R1 rvalid", {7'd0, cpu_rvalid}, 8'd0);
    check_outputs();
    for (int a = 0; a < 16; a++) step(0, 1, 4'(a), 0);
    // R2 low field only, then bit 7 only
    s0_next = 8'hFF; s0_we = 2'b01; step(0, 0, 0, 0);
    s0_we = 2'b10; s0_next = 8'h80; step(0, 1, 0, 0);
    hw_idle(); step(0, 1, 0, 0);
    // R12 conflict on slot 0 and slot 8
    s0_we = 2'b11; s0_next = 8'h55; step(1, 0, 0, 8'h2A);
    s8_we = 2'b11; s8_next = 8'h11; step(1, 0, 8, 8'hC3);
    hw_idle(); step(0, 1, 0, 0);
    // R3 active-low load on slot 2
    s2_next = 8'hF0; s2_we_n = 2'b11; step(0, 1, 2, 0);
    s2_we_n = 2'b10; step(0, 1, 2, 0);
    s2_we_n = 2'b01; step(0, 1, 2, 0);
    hw_idle(); step(0, 1, 2, 0);
    // R4 slots 1 and 3
    step(1, 0, 1, 8'h7E); step(1, 0, 3, 8'h81); step(0, 1, 1, 0); step(0, 1, 3, 0);
    // R5 slot 4: CPU write ignored, hardware load applies
    step(1, 0, 4, 8'hFF); step(0, 1, 4, 0);
    s4_we = 2'b11; s4_next = 8'hB4; step(0, 0, 4, 0);
    hw_idle(); step(0, 1, 4, 0);
    // R6 constants
    step(1, 0, 5, 8'h00); step(0, 1, 5, 0); step(1, 0, 7, 8'hFF); step(0, 1, 7, 0);
    // R7 / R9 wire slot with bit 7
    s6_in = 8'h81; step(1, 1, 6, 8'h00);
    s6_in = 8'h00; step(0, 1, 6, 0);
    s6_in = 8'h80; step(0, 1, 6, 0);
    // R8 write-only slots
    step(1, 0, 8, 8'h80); step(1, 0, 9, 8'h01); step(0, 1, 8, 0); step(0, 1, 9, 0);
    // R11 unmapped
    step(1, 0, 12, 8'hFF); step(1, 1, 15, 8'hAA); step(0, 1, 10, 0);
    for (int a = 0; a < 10; a++) step(0, 1, 4'(a), 0);
    // R10 back-to-back reads then idle
    step(0, 1, 1, 0); step(0, 1, 3, 0); step(0, 0, 0, 0);
    // mixed random
    for (int i = 0; i < 1500; i++) begin
      s0_next = 8'($urandom); s2_next = 8'($urandom); s4_next = 8'($urandom);
      s8_next = 8'($urandom); s6_in = 8'($urandom);
      s0_we = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      s2_we_n = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
      s4_we = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      s8_we = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      step(1'($urandom % 3 == 0), 1'($urandom % 2), 4'($urandom), 8'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule